// File: doc/BRIEF.md
# SAR ADC Conversion Timing Controller

This block is the digital sequencer that sits beside a successive-approximation converter's analog core. When a start request arrives, it first holds a sample phase whose length is set by a power-of-two code. It then runs a bit-serial binary search. During the search it drives a trial code onto a DAC bus and reads back a one-bit comparator decision. The comparator and the DAC are outside the block and are seen only as ports.

Timing is counted in converter-clock periods. The converter clock is an enable tick derived from the system clock by a programmable divider.

Configuration is held in a small register that is loaded through a write strobe. That register sets the resolution (8, 10 or 12 bits), the divider and the sample-length code. A start request takes a snapshot of the configuration, so writes made during a conversion take effect only on the next one. The finished result is right-aligned in a 12-bit word. A one-cycle done pulse marks the moment the result is written.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The 3-bit resolution code selects the bit count: 0 gives 8 bits, 1 gives 10 bits, 2 gives 12 bits, and every other code gives 12 bits.
- R2: After reset the configuration register holds 10-bit resolution, divider code 0 and sample code 0.
- R3: The sample phase lasts 4 << code converter periods for sample codes 0..8, and 1024 periods for codes 9..15.
- R4: The conversion phase lasts N+2 converter periods, where N is the resolution. With a start sampled at a clock edge, done is high after exactly (L+N+2)*D further edges, where L is the sample length and D is the divider period.
- R5: The converter period D equals the 3-bit divider code plus one system clocks.
- R6: Bits are tested most significant first, and a bit is kept when the comparator input is 1 (analog value at or above the trial code). The result is therefore the analog value truncated to N bits and saturated at 2^N-1.
- R7: The result is right-aligned, so bits N and above are zero.
- R8: A start request while busy is ignored. A configuration write during a conversion does not change that conversion's timing or result, but applies to the next conversion.
- R9: busy is high from the edge that accepts a start until the edge that raises done. done is high for exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_res | input | 3 | Resolution code |
| cfg_div | input | 3 | Divider code (period = code+1) |
| cfg_sht | input | 4 | Sample-length code |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator decision: 1 when the analog value is at or above dac_code |
| dac_code | output | 12 | Trial code to the DAC, right-aligned |
| result | output | 12 | Conversion result, right-aligned |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
The hardest situation to reach is a start request and a configuration write that land in the middle of a running conversion. This matters because a wrong snapshot shows only as a changed cycle count or a differently aligned result. The bench therefore opens a long conversion and, partway through the sample phase, pulses start again and writes a new resolution, divider and sample code. It then checks that the running conversion keeps the old edge count and value, and that the next conversion follows the new settings. Saturating analog values and values exactly equal to a trial code exercise the at-or-above decision.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_MAX = 12;
  localparam int RES_W   = 4;   // holds 8..12
  localparam int SHT_W   = 4;
  localparam int SHT_TOP = 8;   // codes above clamp here
  localparam int LEN_W   = SHT_TOP + 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seq_state_t;

  function automatic logic [RES_W-1:0] res_decode(input logic [2:0] code);
    case (code)
      3'd0:    res_decode = 4'd8;
      3'd1:    res_decode = 4'd10;
      default: res_decode = 4'd12;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] sample_len(input logic [SHT_W-1:0] code);
    logic [SHT_W-1:0] c;
    c = (code > SHT_W'(SHT_TOP)) ? SHT_W'(SHT_TOP) : code;
    sample_len = LEN_W'(4) << c;
  endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div_code);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= tick ? '0 : cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && div_code != '0 && $stable(div_code)) |=> !tick) // R5
    else $error("tick repeated with divider above one");
endmodule

// File: rtl/sar_sample_timer.sv
module sar_sample_timer
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [SHT_W-1:0] sht_code,
  output logic             expire
);
  localparam int CNT_W = LEN_W - 1;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cnt;

  assign len    = sample_len(sht_code);
  assign expire = en && tick && ({1'b0, cnt} == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && tick) cnt <= expire ? '0 : cnt + 1'b1;
  end

  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |-> ({1'b0, cnt} < len)) // R3
    else $error("sample counter passed its length");
endmodule

// File: rtl/sar_approx.sv
module sar_approx
  import sar_pkg::*;
#(
  parameter int W = RES_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [RES_W-1:0] res_bits,
  input  logic             cmp_in,
  output logic [W-1:0]     dac_code,
  output logic [W-1:0]     acc,
  output logic             fin
);
  logic [RES_W-1:0] per;
  logic [W-1:0]     mask;
  logic [W-1:0]     acc_nx;
  logic [W-1:0]     one;

  assign one    = W'(1);
  assign fin    = en && tick && (per == res_bits + 4'd1);
  assign acc_nx = cmp_in ? (acc | mask) : acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      per      <= '0;
      mask     <= '0;
      acc      <= '0;
      dac_code <= '0;
    end else if (en && tick) begin
      per <= per + 1'b1;
      if (per == '0) begin
        mask     <= one << (res_bits - 4'd1);
        dac_code <= one << (res_bits - 4'd1);
      end else if (per <= res_bits) begin
        acc      <= acc_nx;
        mask     <= mask >> 1;
        dac_code <= acc_nx | (mask >> 1);
      end
    end
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask)) // R6
    else $error("more than one trial bit");
  AST_DAC_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (res_bits == 4'd8) |-> (dac_code[W-1:8] == '0)) // R7
    else $error("trial code outside 8-bit range");
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int W     = RES_MAX,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_res,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [SHT_W-1:0] cfg_sht,
  input  logic             start,
  input  logic             cmp_in,
  output logic [W-1:0]     dac_code,
  output logic [W-1:0]     result,
  output logic             busy,
  output logic             done
);
  seq_state_t       state;
  logic [2:0]       reg_res;
  logic [DIV_W-1:0] reg_div;
  logic [SHT_W-1:0] reg_sht;
  logic [RES_W-1:0] act_res;
  logic [DIV_W-1:0] act_div;
  logic [SHT_W-1:0] act_sht;
  logic             accept, tick, expire, fin;
  logic [W-1:0]     acc;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  // configuration register, defaults to 10-bit / div 1 / 4-cycle sample
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_res <= 3'd1;
      reg_div <= '0;
      reg_sht <= '0;
    end else if (cfg_we) begin
      reg_res <= cfg_res;
      reg_div <= cfg_div;
      reg_sht <= cfg_sht;
    end
  end

  // snapshot on accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      act_res <= 4'd10;
      act_div <= '0;
      act_sht <= '0;
    end else if (accept) begin
      act_res <= res_decode(reg_res);
      act_div <= reg_div;
      act_sht <= reg_sht;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:   if (accept) state <= ST_SAMPLE;
        ST_SAMPLE: if (expire) state <= ST_CONV;
        ST_CONV:   if (fin) begin
          state  <= ST_IDLE;
          result <= acc;
          done   <= 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  sar_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(accept), .en(busy),
    .div_code(act_div), .tick(tick)
  );

  sar_sample_timer u_smp (
    .clk(clk), .rst(rst), .clr(accept), .en(state == ST_SAMPLE),
    .tick(tick), .sht_code(act_sht), .expire(expire)
  );

  sar_approx #(.W(W)) u_sar (
    .clk(clk), .rst(rst), .clr(accept), .en(state == ST_CONV),
    .tick(tick), .res_bits(act_res), .cmp_in(cmp_in),
    .dac_code(dac_code), .acc(acc), .fin(fin)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) // R9
    else $error("done wider than one cycle");
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) // R9
    else $error("done while busy");
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)) // R9
    else $error("busy rose without start");
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(accept)) |-> $stable(act_res)) // R8
    else $error("resolution changed mid conversion");
  AST_RESULT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (done && act_res == 4'd10) |-> (result[W-1:10] == '0)) // R7
    else $error("10-bit result not right-aligned");
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_res = '0;
  logic [2:0]  cfg_div = '0;
  logic [3:0]  cfg_sht = '0;
  logic        start = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code, result;
  logic        busy, done;
  int          vin = 0;
  int          n_tests = 0, n_fail = 0, cyc = 0;
  int          e_n = 10, e_d = 1, e_l = 4;

  always #4 clk = ~clk;  // 125 MHz

  assign cmp_in = (vin >= int'(dac_code));

  sar_seq_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_res(cfg_res),
    .cfg_div(cfg_div), .cfg_sht(cfg_sht), .start(start), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bits_of(input int code);
    return (code == 0) ? 8 : (code == 1) ? 10 : 12;
  endfunction

  task automatic load_cfg(input int rc, input int dc, input int sc);
    @(negedge clk);
    cfg_res = 3'(rc); cfg_div = 3'(dc); cfg_sht = 4'(sc); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    e_n = bits_of(rc); e_d = dc + 1; e_l = (sc > 8) ? 1024 : (4 << sc);
  endtask

  // mid: edge at which a second start and a config write are injected (0 = none)
  task automatic conv(input int v, input string req, input int mid,
                      input int rc, input int dc, input int sc);
    int n, maxv, exp_r, exp_c;
    maxv  = (1 << e_n) - 1;
    exp_r = (v > maxv) ? maxv : v;
    exp_c = (e_l + e_n + 2) * e_d;
    vin = v;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check({req, " R9 busy after start"}, int'(busy), 1);
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == mid) begin
        start = 1'b1; cfg_we = 1'b1;
        cfg_res = 3'(rc); cfg_div = 3'(dc); cfg_sht = 4'(sc);
        @(negedge clk); n++;
        start = 1'b0; cfg_we = 1'b0;
      end
    end
    check({req, " R4 done edge"}, n, exp_c);
    check({req, " R6 result"}, int'(result), exp_r);
    check({req, " R9 busy low with done"}, int'(busy), 0);
    @(negedge clk);
    check({req, " R9 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset;
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset done", int'(done), 0);
    check("R7 reset result", int'(result), 0);
    check("R6 reset dac", int'(dac_code), 0);
  endtask

  task automatic t_default;
    conv(700, "R2 default 10b", 0, 0, 0, 0);
    conv(5000, "R2 saturate 10b", 0, 0, 0, 0);
  endtask

  task automatic t_res;
    load_cfg(0, 0, 0); conv(4095, "R7 R1 8b saturate", 0, 0, 0, 0);
    conv(128, "R6 8b equal msb", 0, 0, 0, 0);
    conv(127, "R6 8b below msb", 0, 0, 0, 0);
    load_cfg(2, 0, 0); conv(12'hABC, "R1 12b", 0, 0, 0, 0);
    load_cfg(5, 0, 0); conv(4095, "R1 code5 12b", 0, 0, 0, 0);
    load_cfg(1, 0, 0); conv(1023, "R1 10b full", 0, 0, 0, 0);
    conv(0, "R6 zero", 0, 0, 0, 0);
  endtask

  task automatic t_sample;
    load_cfg(1, 0, 3); conv(333, "R3 code3", 0, 0, 0, 0);
    load_cfg(0, 0, 8); conv(77, "R3 code8", 0, 0, 0, 0);
    load_cfg(0, 0, 15); conv(200, "R3 code15 clamp", 0, 0, 0, 0);
  endtask

  task automatic t_div;
    load_cfg(2, 2, 1); conv(1234, "R5 div3", 0, 0, 0, 0);
    load_cfg(0, 7, 0); conv(99, "R5 div8", 0, 0, 0, 0);
  endtask

  task automatic t_busy;
    load_cfg(2, 1, 2);  // 12b, D=2, L=16
    conv(2049, "R8 restart ignored", 10, 0, 4, 0);
    e_n = 8; e_d = 5; e_l = 4;
    conv(2049, "R8 new cfg next", 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_default;
    t_res;
    t_sample;
    t_div;
    t_busy;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule